// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Logic

This block generates the message-passing interrupts for a memory shared by four ports. The highest locations of the address space are set aside as mailboxes, one for each port. When any other port writes into a port's mailbox, that port's interrupt output goes low. The interrupt stays low until the owning port reads its own mailbox.

All ports share one clock. The block only observes each port's write strobe, read strobe and address; the mailbox data itself lives in the main array outside this block. Each interrupt is a registered, active-low flag. Each flag has a single set source, the combined writes from the other ports, and a single clear source, the owner's read. A set and a clear in the same cycle resolve to set.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is low, and on the first clock edge after it, every `irq_n` bit is high.
- R2: The mailbox of port p (0-based) is at address 2^ADDR_W − NPORTS + p. With four ports and a 4-bit address these are 12, 13, 14 and 15.
- R3: If a port other than p writes (`wr_stb` high) to port p's mailbox, `irq_n[p]` is low after the next rising edge.
- R4: When no set and no clear reaches a flag, the flag keeps its value across the edge.
- R5: If port p reads (`rd_stb` high) its own mailbox, `irq_n[p]` returns high after the next rising edge, unless a set reaches it in the same cycle.
- R6: A write by port p to its own mailbox leaves `irq_n[p]` unchanged.
- R7: A read of port p's mailbox by any other port does not clear `irq_n[p]`.
- R8: When a set and a clear of the same flag happen in one cycle, the flag ends up asserted (low).
- R9: A read or write to an address outside the mailbox range has no effect on any flag.
- R10: Several ports can write to different mailboxes in one cycle. Each flag that is hit is set independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | NPORTS | Write strobe per port, active high |
| rd_stb | input | NPORTS | Read strobe per port, active high |
| addr_flat | input | NPORTS*ADDR_W | Port addresses; port p occupies bits [p*ADDR_W +: ADDR_W] |
| irq_n | output | NPORTS | Mailbox interrupt per port, active low |

## Verification
Each flag has one register between the strobes and the pin. A write or read applied in cycle N is therefore visible on `irq_n` after the edge that ends cycle N. The bench drives the strobes on a falling edge. It then compares all four flags with its own arithmetic model on the following falling edge, exactly one rising edge later. It then drops the strobes, so each access lasts exactly one cycle. Hold behaviour is checked on an idle cycle that follows each access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Largest address width the slot arithmetic supports (32-bit math).
  localparam int unsigned MBX_MAX_AW = 16;

  // Address of the mailbox owned by port idx: top of space minus (np-1-idx).
  function automatic int unsigned mbx_slot_addr(input int unsigned aw,
                                                input int unsigned np,
                                                input int unsigned idx);
    int unsigned span;
    span = 32'd1 << aw;
    return span - np + idx;
  endfunction

  // True when addr (zero-extended) selects the mailbox of port idx.
  function automatic logic mbx_is_slot(input int unsigned addr,
                                       input int unsigned aw,
                                       input int unsigned np,
                                       input int unsigned idx);
    return addr == mbx_slot_addr(aw, np, idx);
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SELF   = 0
) (
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [NPORTS-1:0] slot_hit,
  output logic [NPORTS-1:0] set_req,
  output logic              own_wr_hit,
  output logic              own_clr
);

  localparam int unsigned PAD_W = 32 - ADDR_W;

  logic [31:0] addr_ext;
  assign addr_ext = {{PAD_W{1'b0}}, addr};

  for (genvar t = 0; t < NPORTS; t++) begin : g_slot
    assign slot_hit[t] = mbx_is_slot(addr_ext, ADDR_W, NPORTS, t);
    if (t == SELF) begin : g_own
      // A port never raises its own flag.
      assign set_req[t] = 1'b0;
    end else begin : g_other
      assign set_req[t] = wr_stb & slot_hit[t];
    end
  end

  assign own_wr_hit = wr_stb & slot_hit[SELF];
  assign own_clr    = rd_stb & slot_hit[SELF];

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_any,
  input  logic clr,
  output logic irq_n
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_any) pend_q <= 1'b1;
    else if (clr)     pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;

  p_set_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> !irq_n);

  p_clear_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_any) |=> irq_n);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_any && !clr) |=> $stable(irq_n));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && clr) |=> !irq_n);

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        wr_stb,
  input  logic [NPORTS-1:0]        rd_stb,
  input  logic [NPORTS*ADDR_W-1:0] addr_flat,
  output logic [NPORTS-1:0]        irq_n
);

  // Per-source rows: set_mat[s][t] = port s requests a set of flag t.
  logic [NPORTS-1:0] set_mat [NPORTS];
  logic [NPORTS-1:0] hit_mat [NPORTS];
  logic [NPORTS-1:0] own_wr_hit;
  logic [NPORTS-1:0] clr_vec;
  logic [NPORTS-1:0] set_any;

  for (genvar s = 0; s < NPORTS; s++) begin : g_dec
    mbx_port_decode #(
      .NPORTS(NPORTS),
      .ADDR_W(ADDR_W),
      .SELF  (s)
    ) u_dec (
      .wr_stb    (wr_stb[s]),
      .rd_stb    (rd_stb[s]),
      .addr      (addr_flat[s*ADDR_W +: ADDR_W]),
      .slot_hit  (hit_mat[s]),
      .set_req   (set_mat[s]),
      .own_wr_hit(own_wr_hit[s]),
      .own_clr   (clr_vec[s])
    );
  end

  // Column OR: a flag is set when any other port targets it.
  always_comb begin
    set_any = '0;
    for (int s = 0; s < NPORTS; s++) begin
      set_any = set_any | set_mat[s];
    end
  end

  for (genvar t = 0; t < NPORTS; t++) begin : g_flag
    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_any(set_any[t]),
      .clr    (clr_vec[t]),
      .irq_n  (irq_n[t])
    );

    localparam logic [NPORTS-1:0] OWN_BIT = NPORTS'(1) << t;

    // Own write alone, with the flag idle, must not raise the flag.
    p_self_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr_hit[t] && ((wr_stb & ~OWN_BIT) == '0) && irq_n[t]) |=> irq_n[t]);
  end

  p_reset_high_r1: assert property (@(posedge clk)
    (!rst_n) |=> (&irq_n));

endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

  localparam int NP   = 4;
  localparam int AW   = 4;
  localparam int BASE = (1 << AW) - NP;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     wr_stb;
  logic [NP-1:0]     rd_stb;
  logic [NP*AW-1:0]  addr_flat;
  logic [NP-1:0]     irq_n;
  logic [NP-1:0]     model_pend;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbx_irq_top #(.NPORTS(NP), .ADDR_W(AW)) i_mbx_irq_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .addr_flat(addr_flat),
    .irq_n    (irq_n)
  );

  function automatic logic [NP-1:0] next_pend(input logic [NP-1:0] cur,
                                              input logic [NP-1:0] w,
                                              input logic [NP-1:0] r,
                                              input logic [NP*AW-1:0] a);
    logic [NP-1:0] nxt;
    nxt = cur;
    for (int t = 0; t < NP; t++) begin
      logic set_t;
      logic clr_t;
      set_t = 1'b0;
      for (int s = 0; s < NP; s++) begin
        if (w[s] && s != t && int'(a[s*AW +: AW]) == BASE + t) set_t = 1'b1;
      end
      clr_t = r[t] && int'(a[t*AW +: AW]) == BASE + t;
      if (set_t)      nxt[t] = 1'b1;
      else if (clr_t) nxt[t] = 1'b0;
    end
    return nxt;
  endfunction

  task automatic check_flags(input string tag);
    for (int t = 0; t < NP; t++) begin
      checks++;
      if (irq_n[t] !== ~model_pend[t]) begin
        failures++;
        $display("FAIL %s: irq_n[%0d] actual=%b expected=%b", tag, t,
                 irq_n[t], ~model_pend[t]);
      end
    end
  endtask

  // One access cycle: drive after a falling edge, sample one rising edge later.
  task automatic apply(input logic [NP-1:0] w, input logic [NP-1:0] r,
                       input logic [NP*AW-1:0] a, input string tag);
    @(negedge clk);
    wr_stb = w; rd_stb = r; addr_flat = a;
    model_pend = next_pend(model_pend, w, r, a);
    @(negedge clk);
    wr_stb = '0; rd_stb = '0;
    check_flags(tag);
  endtask

  // Mailboxes 12..15, each port p reading slot BASE+p: R5 clear-all pattern.
  localparam logic [NP*AW-1:0] OWN_SLOTS  = 16'hFEDC;
  // Port s writes the mailbox of port (s+1)%4: R10 multi-writer pattern.
  localparam logic [NP*AW-1:0] RING_SLOTS = 16'hCFED;

  initial begin
    rst_n = 1'b0; wr_stb = '0; rd_stb = '0; addr_flat = '0; model_pend = '0;
    repeat (3) @(negedge clk);
    check_flags("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R1 after release");

    // Write sweep: every source, every address (R2, R3, R6, R9), then hold, then clear.
    for (int s = 0; s < NP; s++) begin
      for (int av = 0; av < (1 << AW); av++) begin
        logic [NP*AW-1:0] a;
        a = '0;
        a[s*AW +: AW] = AW'(av);
        apply(NP'(1) << s, '0, a, "R2 R3 R6 R9 write");
        apply('0, '0, a, "R4 hold");
        apply('0, '1, OWN_SLOTS, "R5 clear");
      end
    end

    // Read sweep: set all flags, then every reader at every address (R5, R7, R9).
    for (int r = 0; r < NP; r++) begin
      for (int av = 0; av < (1 << AW); av++) begin
        logic [NP*AW-1:0] a;
        apply('1, '0, RING_SLOTS, "R10 multi set");
        a = '0;
        a[r*AW +: AW] = AW'(av);
        apply('0, NP'(1) << r, a, "R5 R7 R9 read");
      end
    end

    // R8: port 1 writes port 0 mailbox while port 0 reads it.
    apply('0, '1, OWN_SLOTS, "R5 clear");
    apply(4'b0010, 4'b0001, 16'h00CC, "R8 set beats clear");
    apply('0, '0, 16'h00CC, "R4 hold after R8");

    // R1: reset in the middle of traffic returns all flags high.
    apply('1, '0, RING_SLOTS, "R10 multi set");
    @(negedge clk);
    rst_n = 1'b0;
    model_pend = '0;
    @(negedge clk);
    check_flags("R1 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R1 after second release");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule